// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Scheduler

This block computes a crossbar configuration for an N-by-N input-queued switch in which every input holds one virtual queue per output. On a start pulse it captures an N×N request matrix. It then runs a fixed number of request–grant–accept rounds, one per clock. The result is a one-to-one pairing of inputs to outputs, presented with a single-cycle done pulse.

In every round, each output that is still free grants one free input that requests it. Each free input then accepts at most one of the grants it received. Each output holds a grant pointer and each input holds an accept pointer. Both selections scan in round-robin order from these pointers, so no port is starved. A pointer advances to one past the port it was paired with. It advances only when the pairing was made in the first round of a run, which prevents bursts of pointer movement that would break fairness. Ports paired in earlier rounds drop out of later rounds, so the matching grows toward maximal.

Top module: `rrm_sched`

## Requirements
- R1: After reset `match_o` and `done_o` are 0, and every grant and accept pointer points at port 0.
- R2: A start is accepted at an edge where no run is in progress. The request matrix is captured at that edge, and `done_o` is high for exactly one cycle, the cycle that follows the ITERS-th edge after the start edge.
- R3: In the result, each input is paired with at most one output and each output with at most one input.
- R4: A pair (i,j) appears in `match_o` only if request bit i*N+j (input i wants output j) was 1 in the captured matrix.
- R5: Between the done pulse and the next accepted start, `match_o` keeps the final matching unchanged.
- R6: An all-zero request matrix yields an all-zero matching.
- R7: In each round, a free output grants the first free requesting input found by scanning upward from its grant pointer, with wrap-around.
- R8: In each round, a free input that has grants accepts the first granting output found by scanning upward from its accept pointer, with wrap-around.
- R9: When a grant is accepted in the first round of a run, the output's grant pointer becomes (input+1) mod N and the input's accept pointer becomes (output+1) mod N. Pairs made in later rounds leave both pointers unchanged.
- R10: A start pulse that arrives during a run is ignored and does not change that run's result.
- R11: Within a run, a pair once made stays made. Later rounds consider only inputs and outputs that are still unpaired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scheduling run with the current request matrix |
| req_i | input | N*N | Request matrix, bit i*N+j set when input i has a cell for output j |
| match_o | output | N*N | Pairing matrix, same bit layout as the request matrix |
| done_o | output | 1 | One-cycle pulse marking the final pairing |

## Verification
The bench keeps its own pointer state and predicts every matching from the round-robin rules. This exposes a design that advances pointers after later rounds, or to the accepted port itself instead of one past it. Such a design diverges after only a few runs of the all-ones matrix, which rotates through different diagonals. Single-bit, full-row, full-column and all-zero patterns target designs that let a port already paired in an earlier round grant or accept again; such a design would produce a double pairing or drop a pair. A start pulse injected in the middle of a run catches a design that restarts or recaptures its requests, because that would shift the done pulse or alter the result.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  localparam int unsigned PORTS_DEF = 4;
  localparam int unsigned ITERS_DEF = 3;

  // pick lowest set bit at or above ptr, else lowest set bit overall
  function automatic logic [31:0] rr_mask(input int unsigned n, input int unsigned ptr);
    logic [31:0] m;
    m = '0;
    for (int unsigned k = 0; k < 32; k++) m[k] = (k >= ptr) && (k < n);
    return m;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N  = 4,
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [PW-1:0] ptr_i,
  output logic [N-1:0]  gnt_o
);
  logic [31:0]  mask_w;
  logic [N-1:0] hi, sel;

  assign mask_w = rrm_pkg::rr_mask(N, 32'(ptr_i));

  always_comb begin
    hi    = req_i & mask_w[N-1:0];
    sel   = (|hi) ? hi : req_i;
    gnt_o = sel & (~sel + N'(1));
  end
endmodule

// File: rtl/rrm_round.sv
module rrm_round #(
  parameter int unsigned N  = 4,
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*N-1:0]  req_i,
  input  logic [N-1:0]    in_free_i,
  input  logic [N-1:0]    out_free_i,
  input  logic [N*PW-1:0] gptr_i,
  input  logic [N*PW-1:0] aptr_i,
  output logic [N*N-1:0]  acc_o
);
  logic [N-1:0] col_req [N];
  logic [N-1:0] col_gnt [N];
  logic [N-1:0] row_gnt [N];
  logic [N-1:0] row_acc [N];

  for (genvar j = 0; j < N; j++) begin : g_out
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign col_req[j][i] = req_i[i*N+j] & in_free_i[i] & out_free_i[j];
      assign row_gnt[i][j] = col_gnt[j][i];
    end
    rr_pick #(.N(N)) u_gnt (
      .req_i(col_req[j]),
      .ptr_i(gptr_i[j*PW +: PW]),
      .gnt_o(col_gnt[j])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_in
    rr_pick #(.N(N)) u_acc (
      .req_i(row_gnt[i]),
      .ptr_i(aptr_i[i*PW +: PW]),
      .gnt_o(row_acc[i])
    );
    assign acc_o[i*N +: N] = row_acc[i];
  end
endmodule

// File: rtl/rrm_sched.sv
module rrm_sched #(
  parameter int unsigned N     = rrm_pkg::PORTS_DEF,
  parameter int unsigned ITERS = rrm_pkg::ITERS_DEF,
  localparam int unsigned PW = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned CW = $clog2(ITERS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N*N-1:0] req_i,
  output logic [N*N-1:0] match_o,
  output logic           done_o
);
  logic [N*N-1:0] req_q, match_q, acc;
  logic [CW-1:0]  cnt_q;
  logic           busy_q, done_q;
  logic [PW-1:0]  gptr_q [N];
  logic [PW-1:0]  aptr_q [N];
  logic [N*PW-1:0] gptr_flat, aptr_flat;
  logic [N-1:0]   in_free, out_free;
  logic           first_rnd;

  for (genvar p = 0; p < N; p++) begin : g_port
    logic [N-1:0] col;
    for (genvar q = 0; q < N; q++) begin : g_col
      assign col[q] = match_q[q*N+p];
    end
    assign in_free[p]  = ~|match_q[p*N +: N];
    assign out_free[p] = ~|col;
    assign gptr_flat[p*PW +: PW] = gptr_q[p];
    assign aptr_flat[p*PW +: PW] = aptr_q[p];
  end

  rrm_round #(.N(N)) u_round (
    .req_i     (req_q),
    .in_free_i (in_free),
    .out_free_i(out_free),
    .gptr_i    (gptr_flat),
    .aptr_i    (aptr_flat),
    .acc_o     (acc)
  );

  assign first_rnd = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= '0;
      match_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        match_q <= match_q | acc;
        cnt_q   <= cnt_q + CW'(1);
        if (cnt_q == CW'(ITERS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start_i) begin
        req_q   <= req_i;
        match_q <= '0;
        cnt_q   <= '0;
        busy_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < N; p++) begin
        gptr_q[p] <= '0;
        aptr_q[p] <= '0;
      end
    end else if (first_rnd) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (acc[i*N+j]) begin
            gptr_q[j] <= PW'((i + 1) % N);
            aptr_q[i] <= PW'((j + 1) % N);
          end
        end
      end
    end
  end

  assign match_o = match_q;
  assign done_o  = done_q;
endmodule

// File: rtl/rrm_sched_chk.sv
module rrm_sched_chk #(
  parameter int unsigned N     = 4,
  parameter int unsigned ITERS = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [N*N-1:0] req_i,
  input logic [N*N-1:0] match_o,
  input logic           done_o,
  input logic           busy_i
);
  logic [N*N-1:0] req_cap;
  int unsigned    since;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_cap <= '0;
      since   <= ITERS + 1;
    end else if (start_i && !busy_i) begin
      req_cap <= req_i;
      since   <= 0;
    end else if (since <= ITERS) begin
      since <= since + 1;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (since == ITERS));

  // R4
  subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((match_o & ~req_cap) == '0));

  // R6
  zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && req_cap == '0) |-> (match_o == '0));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(match_o));

  // R11
  grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (($past(match_o) & ~match_o) == '0));

  for (genvar p = 0; p < N; p++) begin : g_oh
    logic [N-1:0] col;
    for (genvar q = 0; q < N; q++) begin : g_c
      assign col[q] = match_o[q*N+p];
    end
    // R3
    row_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(match_o[p*N +: N]));
    // R3
    col_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col));
  end
endmodule

bind rrm_sched rrm_sched_chk #(.N(N), .ITERS(ITERS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .req_i  (req_i),
  .match_o(match_o),
  .done_o (done_o),
  .busy_i (busy_q)
);

// File: tb/tb_rrm_sched.sv
`timescale 1ns/1ps
module tb_rrm_sched;
  localparam int N  = 4;
  localparam int IT = 3;
  localparam int NN = N * N;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [NN-1:0] req_i = '0;
  logic [NN-1:0] match_o;
  logic          done_o;

  always #2.5 clk_i = ~clk_i;

  rrm_sched #(.N(N), .ITERS(IT)) dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .req_i  (req_i),
    .match_o(match_o),
    .done_o (done_o)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int gp [N];
  int ap [N];
  logic [31:0] lfsr = 32'h1234_5678;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog R2 act=%0d exp<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [NN-1:0] act, input logic [NN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit one_to_one(input logic [NN-1:0] m);
    for (int p = 0; p < N; p++) begin
      int rc = 0, cc = 0;
      for (int q = 0; q < N; q++) begin
        rc += m[p*N+q];
        cc += m[q*N+p];
      end
      if (rc > 1 || cc > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  // reference: round-robin request/grant/accept from the requirements (R7, R8, R9, R11)
  function automatic logic [NN-1:0] model(input logic [NN-1:0] r);
    logic [NN-1:0] m = '0;
    for (int it = 0; it < IT; it++) begin
      int gsel [N];
      bit ifree [N];
      bit ofree [N];
      for (int p = 0; p < N; p++) begin
        ifree[p] = 1'b1; ofree[p] = 1'b1;
        for (int q = 0; q < N; q++) begin
          if (m[p*N+q]) ifree[p] = 1'b0;
          if (m[q*N+p]) ofree[p] = 1'b0;
        end
      end
      for (int j = 0; j < N; j++) begin
        gsel[j] = -1;
        if (ofree[j])
          for (int k = 0; k < N; k++) begin
            int i = (gp[j] + k) % N;
            if (gsel[j] < 0 && ifree[i] && r[i*N+j]) gsel[j] = i;
          end
      end
      for (int i = 0; i < N; i++) begin
        int sj = -1;
        if (ifree[i])
          for (int k = 0; k < N; k++) begin
            int j = (ap[i] + k) % N;
            if (sj < 0 && gsel[j] == i) sj = j;
          end
        if (sj >= 0) begin
          m[i*N+sj] = 1'b1;
          if (it == 0) begin
            gp[sj] = (i + 1) % N;
            ap[i]  = (sj + 1) % N;
          end
        end
      end
    end
    return m;
  endfunction

  task automatic run(input logic [NN-1:0] r, input bit noise, input string tag);
    logic [NN-1:0] exp;
    exp = model(r);
    @(negedge clk_i);
    start_i = 1'b1; req_i = r;
    @(negedge clk_i);
    start_i = noise; req_i = ~r;   // R10: start during run must be ignored
    @(negedge clk_i);
    start_i = 1'b0; req_i = '0;
    repeat (IT - 1) @(negedge clk_i);
    chk(done_o === 1'b1, "R2 done high", NN'(done_o), NN'(1));
    chk(match_o === exp, tag, match_o, exp);
    chk(one_to_one(match_o), "R3 one-to-one", match_o, exp);
    chk((match_o & ~r) == '0, "R4 subset", match_o, r);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R2 done single cycle", NN'(done_o), NN'(0));
    chk(match_o === exp, "R5 hold", match_o, exp);
  endtask

  initial begin
    for (int p = 0; p < N; p++) begin gp[p] = 0; ap[p] = 0; end
    repeat (3) @(negedge clk_i);
    chk(match_o === '0, "R1 reset match", match_o, '0);
    chk(done_o === 1'b0, "R1 reset done", NN'(done_o), NN'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(match_o === '0 && done_o === 1'b0, "R1 after release", match_o, '0);

    // R1/R9: all-ones from zero pointers gives diagonal 0,1,2; repeated runs rotate
    run('1, 1'b0, "R9 first all-ones");
    chk(match_o === NN'(16'h0421), "R1 zero-pointer result", match_o, NN'(16'h0421));
    for (int n = 0; n < 6; n++) run('1, 1'b0, "R9 pointer rotation");

    run('0, 1'b0, "R6 zero request");
    chk(match_o === '0, "R6 zero match", match_o, '0);

    for (int b = 0; b < NN; b++) run(NN'(1) << b, 1'b0, "R7 single request");
    for (int p = 0; p < N; p++) run(NN'({N{1'b1}}) << (p*N), 1'b0, "R8 full row");
    for (int p = 0; p < N; p++) begin
      logic [NN-1:0] c = '0;
      for (int q = 0; q < N; q++) c[q*N+p] = 1'b1;
      run(c, 1'b0, "R7 full column");
    end

    for (int n = 0; n < 40; n++) run(lfsr[NN-1:0] | NN'(1), 1'b1, "R10 start during run");

    for (int n = 0; n < 2500; n++) begin
      logic [NN-1:0] r;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      r = (n % 3 == 0) ? (lfsr[NN-1:0] & lfsr[NN+NN-1:NN]) : lfsr[NN-1:0];
      run(r, 1'b0, "R11 R8 R7 sweep");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule